// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is a slave device on a two-wire serial bus (SCL clock, open-drain SDA data). It fronts a 4096 x 8 byte memory held in an internal register array. SCL and SDA are resynchronised onto the system clock, and the block detects START and STOP conditions from the sampled lines. It answers only when the device address it receives matches a fixed type code combined with three strap pins.

A write transfer carries two word-address bytes and then up to 32 data bytes. The data bytes are gathered in a page buffer and committed to the array in one step when STOP arrives. A self-timed busy period then follows. During that period the slave ignores its own address, so a master can poll it for completion. A write-protect input keeps the upper half of the array unchanged.

A read transfer can return the byte at the current address. A random read sets the address with an address-only write and a repeated START. Sequential reads walk the array through an incrementing address counter that wraps at the top of memory.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: SDA falling while SCL is high is a START. A START at any bit position drops the byte in progress and restarts device-address reception. SDA rising while SCL is high is a STOP: the slave goes idle and releases SDA.
- R2: The device address byte is {4'b1010, A2, A1, A0, RW}, sent MSB first, and bit 0 set to 1 means read. On a mismatch the slave gives no ACK and ignores the bytes that follow until the next START.
- R3: The slave pulls SDA low through the ninth SCL clock of every byte it accepts. The slave changes its SDA drive only while SCL is low, except when a START or STOP releases it.
- R4: After a write device address, the first byte gives word-address bits 11:8 in its low nibble and its upper nibble is ignored. The second byte gives bits 7:0.
- R5: Data bytes in a write are buffered and committed on STOP. Bits 4:0 of the address advance and wrap inside the 32-byte page while bits 11:5 stay fixed, so any byte past the 32nd overwrites an earlier one.
- R6: A repeated START before STOP discards the buffered write data. The array is unchanged and no busy period starts.
- R7: A committed write starts a busy period of WRITE_CYCLES system clocks. While busy, the slave does not acknowledge its device address. After the busy period ends it acknowledges again.
- R8: While the write-protect input is high, locations whose address bit 11 is set (0x800-0xFFF) keep their contents. The bytes are still acknowledged, and the lower half is still written. When the input is low, the upper half is writable.
- R9: A read device address with no address phase returns the byte at the address counter, which points one past the last byte accessed.
- R10: An address-only write followed by a repeated START and a read device address returns the byte at the given address.
- R11: Each master ACK in a read advances the counter by one across the whole array, wrapping from 0xFFF to 0x000. A master NACK ends the read with SDA released.
- R12: After reset, SDA is released and the slave is not busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as sampled from the bus |
| sda_i | input | 1 | Serial data line as sampled from the bus |
| sda_oe | output | 1 | When 1, the slave pulls SDA low (open drain) |
| addr_strap | input | 3 | Device address strap pins A2..A0 |
| wp_i | input | 1 | Write protect for the upper half of the array |

## Verification
Each SCL edge reaches the control logic two system clocks after the pin changes, and the slave's response on sda_oe appears one clock later. Any ACK or read data bit is therefore settled three clocks after the SCL fall that triggers it. The bench holds SCL low for a quarter period of eight clocks before each rise and samples SDA midway through the high phase, so every bit is read well after it has settled. A commit happens on the clock that registers STOP. The busy window is checked at two points: a poll that starts at once must find the slave unacknowledged, and a poll made WRITE_CYCLES plus a margin later must find it acknowledged.

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave #(
  parameter int          ADDR_W       = 12,
  parameter int          PAGE_W       = 5,
  parameter int          WRITE_CYCLES = 300000,
  parameter logic [3:0]  DEV_TYPE     = 4'b1010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [2:0] addr_strap,
  input  logic       wp_i
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAGE  = 1 << PAGE_W;
  localparam int CW    = $clog2(WRITE_CYCLES + 1);
  localparam int HI_W  = ADDR_W - 8;

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_AHI, S_ALO, S_WR, S_RD} st_t;

  logic [2:0] scl_q, sda_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end

  wire scl_s = scl_q[1], scl_d = scl_q[2];
  wire sda_s = sda_q[1], sda_d = sda_q[2];
  wire scl_rise = scl_s & ~scl_d;
  wire scl_fall = ~scl_s & scl_d;
  wire start = scl_s & scl_d & sda_d & ~sda_s;
  wire stop  = scl_s & scl_d & ~sda_d & sda_s;

  logic [7:0]        mem [DEPTH];
  logic [7:0]        pbuf [PAGE];
  logic [PAGE-1:0]   pvalid;
  logic [ADDR_W-1:0] ptr;
  logic [7:0]        shreg, obyte;
  logic [3:0]        bitcnt;
  logic              mack, rd_first;
  logic [CW-1:0]     busy_cnt;
  st_t               st;

  wire busy      = busy_cnt != '0;
  wire byte_done = scl_fall && bitcnt == 4'd8;
  wire ack_done  = scl_fall && bitcnt == 4'd9;
  wire dev_hit   = shreg[7:1] == {DEV_TYPE, addr_strap} && !busy;
  wire commit    = stop && st == S_WR && |pvalid;
  wire [ADDR_W-1:0] ptr_pg = {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + 1'b1};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; bitcnt <= '0; sda_oe <= 1'b0; pvalid <= '0;
      ptr <= '0; shreg <= '0; obyte <= '0; mack <= 1'b0; rd_first <= 1'b0;
      busy_cnt <= '0;
    end else begin
      if (busy) busy_cnt <= busy_cnt - 1'b1;
      if (start) begin
        st <= S_DEV; bitcnt <= '0; sda_oe <= 1'b0; pvalid <= '0;
      end else if (stop) begin
        st <= S_IDLE; bitcnt <= '0; sda_oe <= 1'b0; pvalid <= '0;
        if (commit) busy_cnt <= CW'(WRITE_CYCLES);
      end else if (st != S_IDLE) begin
        if (scl_rise) begin
          if (bitcnt < 4'd8) begin
            shreg  <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 1'b1;
          end else if (bitcnt == 4'd8) begin
            mack   <= ~sda_s;
            bitcnt <= 4'd9;
          end
        end
        if (byte_done) begin
          sda_oe <= 1'b1;
          case (st)
            S_DEV: if (dev_hit) begin
                     st <= shreg[0] ? S_RD : S_AHI;
                     rd_first <= shreg[0];
                   end else begin
                     st <= S_IDLE; sda_oe <= 1'b0;
                   end
            S_AHI: begin ptr[ADDR_W-1:8] <= shreg[HI_W-1:0]; st <= S_ALO; end
            S_ALO: begin ptr[7:0] <= shreg; st <= S_WR; end
            S_WR:  begin pvalid[ptr[PAGE_W-1:0]] <= 1'b1; ptr <= ptr_pg; end
            S_RD:  begin sda_oe <= 1'b0; ptr <= ptr + 1'b1; end
            default: sda_oe <= 1'b0;
          endcase
        end
        if (ack_done) begin
          bitcnt <= '0;
          sda_oe <= 1'b0;
          if (st == S_RD) begin
            if (rd_first || mack) begin
              obyte <= mem[ptr]; sda_oe <= ~mem[ptr][7]; rd_first <= 1'b0;
            end else st <= S_IDLE;
          end
        end
        if (scl_fall && st == S_RD && bitcnt >= 4'd1 && bitcnt <= 4'd7)
          sda_oe <= ~obyte[3'd7 - bitcnt[2:0]];
      end
    end

  always_ff @(posedge clk) begin
    if (byte_done && st == S_WR) pbuf[ptr[PAGE_W-1:0]] <= shreg;
    if (commit)
      for (int i = 0; i < PAGE; i++)
        if (pvalid[i] && !(wp_i && ptr[ADDR_W-1]))
          mem[{ptr[ADDR_W-1:PAGE_W], PAGE_W'(i)}] <= pbuf[i];
  end

  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> (!$past(scl_s) || $past(start) || $past(stop))); // R3
  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (st == S_IDLE && !sda_oe)); // R1
  AST_BUSY_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && st == S_DEV && busy && !start && !stop) |=> !sda_oe); // R7
  AST_BUSY_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !commit) |=> busy_cnt == $past(busy_cnt) - 1'b1); // R7
  AST_PAGE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WR && $past(st) == S_WR) |-> ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W])); // R5
  AST_READ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RD && $past(st) == S_RD && ptr != $past(ptr)) |-> ptr == $past(ptr) + 1'b1); // R11
endmodule

// File: tb/i2c_eeprom_slave_test.sv
module i2c_eeprom_slave_test;
  localparam int CLK_NS = 10;
  localparam int Q      = 8;
  localparam int WC     = 400;
  localparam logic [7:0] DEV_W = 8'hAA;
  localparam logic [7:0] DEV_R = 8'hAB;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1, wp = 1'b0;
  logic [2:0] strap = 3'b101;
  wire sda_oe;
  wire sda_line = sda_m & ~sda_oe;

  i2c_eeprom_slave #(.WRITE_CYCLES(WC)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .addr_strap(strap), .wp_i(wp));

  always #(CLK_NS/2) clk = ~clk;

  int checks = 0, fails = 0;
  logic [7:0] model [4096];

  function automatic logic [7:0] pat(input logic [11:0] a);
    return 8'(int'(a) * 37 + (int'(a) >> 5));
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic hold(input int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start;
    scl = 1'b0; hold(Q); sda_m = 1'b1; hold(Q);
    scl = 1'b1; hold(2*Q); sda_m = 1'b0; hold(2*Q); scl = 1'b0; hold(Q);
  endtask

  task automatic bus_stop;
    scl = 1'b0; hold(Q); sda_m = 1'b0; hold(Q);
    scl = 1'b1; hold(2*Q); sda_m = 1'b1; hold(2*Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      sda_m = b[7-i]; hold(Q); scl = 1'b1; hold(2*Q); scl = 1'b0; hold(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    sda_m = 1'b1; hold(Q); scl = 1'b1; hold(Q); ack = ~sda_line;
    hold(Q); scl = 1'b0; hold(Q);
  endtask

  task automatic recv_byte(input logic ack_it, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      hold(Q); scl = 1'b1; hold(Q); b[7-i] = sda_line; hold(Q); scl = 1'b0;
    end
    sda_m = ~ack_it; hold(Q); scl = 1'b1; hold(2*Q); scl = 1'b0; hold(Q);
    sda_m = 1'b1;
  endtask

  task automatic set_addr(input logic [11:0] a, input logic [3:0] junk);
    logic ack;
    bus_start;
    send_byte(DEV_W, ack);           chk(ack, "R3 dev ack", ack, 1);
    send_byte({junk, a[11:8]}, ack); chk(ack, "R4 hi ack", ack, 1);
    send_byte(a[7:0], ack);          chk(ack, "R4 lo ack", ack, 1);
  endtask

  task automatic wr_bytes(input logic [11:0] a, input int n, input logic [7:0] seed,
                          input logic [3:0] junk);
    logic ack;
    set_addr(a, junk);
    for (int i = 0; i < n; i++) begin
      logic [11:0] ai;
      logic [7:0]  d;
      ai = {a[11:5], 5'(a[4:0] + 5'(i))};
      d  = pat(ai) ^ seed;
      send_byte(d, ack);
      chk(ack, "R8 data ack", ack, 1);
      if (!(wp && ai[11])) model[ai] = d;
    end
    bus_stop;
    hold(WC + 60);
  endtask

  task automatic rd_seq(input logic [11:0] a, input int n, input string req);
    logic ack;
    logic [7:0] b;
    set_addr(a, 4'h0);
    bus_start;
    send_byte(DEV_R, ack); chk(ack, "R10 read dev ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      logic [11:0] ai;
      ai = 12'(a + 12'(i));
      recv_byte(i < n - 1, b);
      chk(b == model[ai], req, b, model[ai]);
    end
    chk(!sda_oe, "R11 release after NACK", sda_oe, 0);
    bus_stop;
  endtask

  task automatic rd_current(input logic [11:0] a);
    logic ack;
    logic [7:0] b;
    bus_start;
    send_byte(DEV_R, ack); chk(ack, "R9 dev ack", ack, 1);
    recv_byte(1'b0, b);
    chk(b == model[a], "R9 current address", b, model[a]);
    bus_stop;
  endtask

  initial begin
    logic ack;
    hold(5);
    chk(!sda_oe, "R12 reset release", sda_oe, 0);
    rst_n = 1'b1;
    hold(5);

    bus_start;
    send_byte(8'hA2, ack); chk(!ack, "R2 mismatch", ack, 0);
    send_byte(8'h00, ack); chk(!ack, "R2 ignored byte", ack, 0);
    bus_stop; hold(Q);

    bus_start;
    send_bits(8'hFF, 3);
    bus_start;
    send_byte(DEV_W, ack); chk(ack, "R1 restart mid-byte", ack, 1);
    bus_stop;
    bus_start;
    send_byte(DEV_W, ack); chk(ack, "R12 not busy", ack, 1);
    bus_stop; hold(Q);

    wr_bytes(12'h040, 32, 8'h00, 4'h0);
    rd_seq(12'h040, 16, "R10 page read");
    rd_current(12'h050);
    rd_seq(12'h051, 15, "R5 full page");

    wr_bytes(12'h13E, 4, 8'h5A, 4'h0);
    rd_seq(12'h120, 2, "R5 page wrap low");
    rd_seq(12'h13E, 2, "R5 page wrap high");
    wr_bytes(12'h200, 34, 8'hC3, 4'h0);
    rd_seq(12'h200, 32, "R5 overwrite");

    wr_bytes(12'h150, 1, 8'h33, 4'hF);
    rd_seq(12'h150, 1, "R4 upper nibble ignored");

    set_addr(12'h300, 4'h0);
    send_byte(8'h42, ack); chk(ack, "R3 data ack", ack, 1);
    bus_stop;
    model[12'h300] = 8'h42;
    bus_start;
    send_byte(DEV_W, ack); chk(!ack, "R7 busy nack", ack, 0);
    bus_stop;
    hold(WC + 60);
    bus_start;
    send_byte(DEV_W, ack); chk(ack, "R7 ready ack", ack, 1);
    bus_stop; hold(Q);
    rd_seq(12'h300, 1, "R7 committed byte");

    wr_bytes(12'h850, 1, 8'h00, 4'h0);
    wp = 1'b1;
    wr_bytes(12'h850, 1, 8'hFF, 4'h0);
    wr_bytes(12'h7F0, 1, 8'h11, 4'h0);
    rd_seq(12'h850, 1, "R8 protected upper");
    rd_seq(12'h7F0, 1, "R8 lower writable");
    wp = 1'b0;
    wr_bytes(12'h850, 1, 8'h0F, 4'h0);
    rd_seq(12'h850, 1, "R8 unprotected upper");

    wr_bytes(12'hFFE, 2, 8'h21, 4'h0);
    wr_bytes(12'h000, 2, 8'h12, 4'h0);
    rd_seq(12'hFFE, 4, "R11 wrap to zero");

    wr_bytes(12'h060, 1, 8'h00, 4'h0);
    set_addr(12'h060, 4'h0);
    send_byte(8'h99, ack);
    bus_start;
    bus_stop;
    bus_start;
    send_byte(DEV_W, ack); chk(ack, "R6 no busy after abort", ack, 1);
    bus_stop; hold(Q);
    rd_seq(12'h060, 1, "R6 abort keeps data");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got 0x0 expected 0x1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule